// File: doc/BRIEF.md
# 16-bit Timer with Two Capture/Compare Registers

This block is a 16-bit up-counter with two capture/compare registers and one toggling timer output. Each register is set to compare or capture through a small control register. In compare mode a register raises its own one-cycle match interrupt. In capture mode it latches the running count when its external trigger pulses. The triggers arrive already edge-qualified, one cycle per valid edge.

The counter has three count modes. In free-running mode it wraps from FFFFH to 0000H. In match-clear mode it returns to zero after it equals register 0. In trigger-clear mode the register-0 trigger returns it to zero. A level input starts and stops counting. Software writes and reads the registers through a simple bus with one address per register. The capture input of register 1 shares a pin with the timer output. When the output is enabled, that capture input is dead.

Top module: `dual_cc_timer`

Register addresses (`addr`): 0 = counter (read only, writes ignored), 1 = register 0, 2 = register 1, 3 = control. Control fields: bit 0 = register 0 capture mode (1 = capture, 0 = compare); bit 1 = the same for register 1; bits 3:2 = count mode (00 free-running, 01 match-clear, 10 trigger-clear, 11 acts as free-running); bit 4 = timer output enable.

## Requirements
- R1: After reset the counter, both registers and the control register read 0. `irq0`, `irq1`, `tout` and `cfg_err` are all low.
- R2: While `run` is high the counter rises by one per cycle and wraps from FFFFH to 0000H. While `run` is low the counter reads 0, so the next start counts again from 0.
- R3: In match-clear mode (control bits 3:2 = 01), the cycle after the counter equals a nonzero register 0 in compare mode, the counter reads 0. The period is therefore register 0 + 1. `cfg_err` is high whenever that mode is selected with register 0 equal to 0.
- R4: A compare match raises that register's interrupt (`irq0` or `irq1`) for exactly one cycle. The pulse comes in the cycle after the counter held the register's value.
- R5: A compare register holding 0 matches only when the counter reaches 0 by wrapping from FFFFH. It does not match at the 0 that follows a start.
- R6: If a compare register is rewritten below the current count, the counter does not clear. It keeps counting upward, and no match occurs until the count next reaches the new value.
- R7: In capture mode, a trigger pulse while running loads the register with the count of that cycle. A register in compare mode ignores its trigger.
- R8: When a capture into a register and a bus read of that same register fall in one cycle, the capture takes effect and `rd_valid` is low for that read. Reads without a collision return `rd_valid` high.
- R9: Reading the counter (address 0) never changes either capture register.
- R10: With the output enabled (control bit 4), `tout` toggles on each register-0 match and `trig1` is ignored. With the output disabled, `trig1` captures normally. `tout` is low while stopped.
- R11: A capture trigger in a cycle with `run` low is discarded, and the register keeps its value.
- R12: In trigger-clear mode (control bits 3:2 = 10), a `trig0` pulse while running makes the counter read 0 in the next cycle, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable; low stops and clears the counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| rd_valid | output | 1 | Read data valid; low on a capture collision |
| trig0 | input | 1 | Register 0 capture / clear trigger pulse |
| trig1 | input | 1 | Register 1 capture trigger pulse (shared with tout) |
| irq0 | output | 1 | Register 0 match interrupt pulse |
| irq1 | output | 1 | Register 1 match interrupt pulse |
| tout | output | 1 | Timer output, toggles on register 0 match |
| cfg_err | output | 1 | Match-clear mode with register 0 equal to zero |

## Verification
Match-clear counting is driven with periods drawn at random. In each cycle the count, interrupt and output level are compared with a modulo model, which separates an off-by-one period from a missed clear. Captures are taken at random counts, which shows that the latched value is the count of the trigger cycle and not the next one. A full wrap with a zero compare and an FFFEH compare separates the post-overflow zero match from a false match at start. Short directed cases cover the collision, stop, shared-pin and rewrite-below-count orderings.

// File: rtl/dual_cc_timer.sv
module dual_cc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         rd_valid,
  input  logic         trig0,
  input  logic         trig1,
  output logic         irq0,
  output logic         irq1,
  output logic         tout,
  output logic         cfg_err
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [1:0] M_FREE = 2'd0, M_MCLR = 2'd1, M_TCLR = 2'd2;

  logic [W-1:0] cnt, r0, r1;
  logic         wrapped;
  logic         cap_md0, cap_md1, oen;
  logic [1:0]   cmode;

  logic wr0, wr1, wrc, cap0_ev, cap1_ev, m0, m1, clr;

  assign wr0 = wr_en && addr == 2'd1;
  assign wr1 = wr_en && addr == 2'd2;
  assign wrc = wr_en && addr == 2'd3;

  assign cap0_ev = run && cap_md0 && trig0;
  assign cap1_ev = run && cap_md1 && trig1 && !oen;

  assign m0 = run && !cap_md0 && cnt == r0 && (r0 != '0 || wrapped);
  assign m1 = run && !cap_md1 && cnt == r1 && (r1 != '0 || wrapped);

  assign clr = (cmode == M_MCLR && m0) || (cmode == M_TCLR && trig0);

  assign cfg_err = cmode == M_MCLR && r0 == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      wrapped <= cnt == TOP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0 <= '0;
      r1 <= '0;
    end else begin
      if (cap0_ev)  r0 <= cnt;
      else if (wr0) r0 <= wdata;
      if (cap1_ev)  r1 <= cnt;
      else if (wr1) r1 <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_md0 <= 1'b0;
      cap_md1 <= 1'b0;
      cmode   <= M_FREE;
      oen     <= 1'b0;
    end else if (wrc) begin
      cap_md0 <= wdata[0];
      cap_md1 <= wdata[1];
      cmode   <= wdata[3:2];
      oen     <= wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
      tout <= 1'b0;
    end else begin
      irq0 <= m0;
      irq1 <= m1;
      if (!run)           tout <= 1'b0;
      else if (oen && m0) tout <= !tout;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = cnt;
      2'd1: rdata = r0;
      2'd2: rdata = r1;
      default: rdata[4:0] = {oen, cmode, cap_md1, cap_md0};
    endcase
  end

  assign rd_valid = rd_en && !(addr == 2'd1 && cap0_ev) && !(addr == 2'd2 && cap1_ev);

  // R2
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R10
  tout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tout);

  // R11
  stop_nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr0) |=> r0 == $past(r0));

  // R7
  cmp_nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_md0 && !wr0) |=> r0 == $past(r0));

  // R10
  shared_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oen && !wr1) |=> r1 == $past(r1));

  // R3
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && $past(cmode) == M_MCLR) |-> cnt == '0);
endmodule

// File: tb/tb_dual_cc_timer.sv
`timescale 1ns/1ps
module tb_dual_cc_timer;
  logic clk = 0, rst_n = 0, run = 0, wr_en = 0, rd_en = 0, trig0 = 0, trig1 = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic rd_valid, irq0, irq1, tout, cfg_err;
  int checks = 0, errors = 0;

  dual_cc_timer #(.W(16)) dut (.clk, .rst_n, .run, .wr_en, .rd_en, .addr, .wdata,
    .rdata, .rd_valid, .trig0, .trig1, .irq0, .irq1, .tout, .cfg_err);

  always #5 clk = ~clk;

  function automatic int exp_cnt(int t, int p);
    return t % p;
  endfunction
  function automatic bit exp_irq(int t, int p);
    return t > 0 && (t % p) == 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = a[1:0]; wdata = d[15:0];
    tick(1);
    wr_en = 0;
  endtask

  task automatic rd(int a, output int v, output bit ok);
    addr = a[1:0]; rd_en = 1; #1;
    v = rdata; ok = rd_valid;
    rd_en = 0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, c, p, k, n;
    bit ok, et;
    void'($urandom(32'd1234));
    tick(2); rst_n = 1; tick(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v, ok); chk("R1 reg", v, 0); end
    chk("R1 irq0", irq0, 0); chk("R1 irq1", irq1, 0);
    chk("R1 tout", tout, 0); chk("R1 cfg_err", cfg_err, 0);

    // R2 count and stop
    run = 1; tick(5); rd(0, v, ok); chk("R2 count", v, 5);
    run = 0; tick(1); rd(0, v, ok); chk("R2 stopped", v, 0);
    run = 1; tick(3); rd(0, v, ok); chk("R2 restart", v, 3);
    run = 0; tick(1);

    // R3 cfg_err on zero in match-clear mode
    wr(1, 0); wr(3, 32'h04); chk("R3 cfg_err", cfg_err, 1);

    // R3 R4 R10 random match-clear periods with output enabled
    for (int it = 0; it < 6; it++) begin
      run = 0; tick(1);
      p = 3 + ($urandom % 39);
      wr(1, p - 1); wr(3, 32'h14);
      chk("R3 cfg_err clear", cfg_err, 0);
      run = 1; et = 0;
      for (int t = 1; t <= 3 * p; t++) begin
        tick(1);
        if (exp_irq(t, p)) et = !et;
        rd(0, v, ok);
        chk("R3 period", v, exp_cnt(t, p));
        chk("R4 irq0 pulse", irq0, exp_irq(t, p));
        chk("R10 tout toggle", tout, et);
      end
      run = 0; tick(1); chk("R10 tout stopped", tout, 0);
    end

    // R6 rewrite below count
    wr(1, 100); wr(3, 32'h04); run = 1; tick(50);
    rd(0, c, ok); wr(1, 20); rd(0, v, ok); chk("R6 no clear", v, c + 1);
    n = 0;
    for (int t = 0; t < 100; t++) begin tick(1); if (irq0) n++; end
    rd(0, v, ok); chk("R6 continues", v, c + 101); chk("R6 no match", n, 0);
    run = 0; tick(1);

    // R7 capture at random count, compare ignores trigger
    wr(2, 32'h1234); wr(3, 32'h01); run = 1;
    for (int it = 0; it < 4; it++) begin
      k = 3 + ($urandom % 60); tick(k);
      rd(0, c, ok); trig0 = 1; trig1 = 1; tick(1); trig0 = 0; trig1 = 0;
      rd(1, v, ok); chk("R7 capture", v, c);
      rd(2, v, ok); chk("R7 compare ignores", v, 32'h1234);
    end

    // R8 collision
    tick(3); rd(0, c, ok);
    trig0 = 1; addr = 1; rd_en = 1; #1; chk("R8 rd_valid low", rd_valid, 0);
    tick(1); trig0 = 0; rd_en = 0;
    rd(1, v, ok); chk("R8 capture wins", v, c); chk("R8 valid after", ok, 1);

    // R9 counter reads
    for (int t = 0; t < 5; t++) begin rd(0, v, ok); tick(1); end
    rd(1, v, ok); chk("R9 no capture on read", v, c);

    // R11 stopped trigger
    run = 0; tick(1); trig0 = 1; tick(1); trig0 = 0;
    rd(1, v, ok); chk("R11 discarded", v, c);

    // R10 shared pin
    wr(2, 32'h0BEE); wr(3, 32'h12); run = 1; tick(7);
    trig1 = 1; tick(1); trig1 = 0;
    rd(2, v, ok); chk("R10 trig1 ignored", v, 32'h0BEE);
    wr(3, 32'h02); tick(2); rd(0, c, ok);
    trig1 = 1; tick(1); trig1 = 0;
    rd(2, v, ok); chk("R10 trig1 captures", v, c);
    run = 0; tick(1);

    // R12 trigger-clear mode
    wr(3, 32'h08); run = 1; tick(10);
    trig0 = 1; tick(1); trig0 = 0;
    rd(0, v, ok); chk("R12 cleared", v, 0);
    tick(4); rd(0, v, ok); chk("R12 continues", v, 4);
    run = 0; tick(1);

    // R5 R2 R4 zero compare across a full wrap
    wr(1, 0); wr(2, 32'hFFFE); wr(3, 0); run = 1;
    tick(1); chk("R5 no match at start", irq0, 0);
    n = 0;
    for (int t = 0; t < 65533; t++) begin tick(1); if (irq0) n++; end
    chk("R5 no early match", n, 0);
    rd(0, v, ok); chk("R2 near top", v, 32'hFFFE);
    tick(1); chk("R4 irq1 match", irq1, 1);
    tick(1); rd(0, v, ok); chk("R2 wrap", v, 0);
    chk("R4 irq1 single", irq1, 0); chk("R5 not yet", irq0, 0);
    tick(1); chk("R5 zero match after wrap", irq0, 1);
    tick(1); chk("R4 irq0 single", irq0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule